// File: doc/BRIEF.md
# Colour-Latching Display Cell

This block models a single display pixel driven by K colour sources. Each source presents a 24-bit colour, an active bit and a legacy flag. The colour is packed red, green, blue, with red in the top byte. The cell has two behaviours, chosen by a mode input.

In latch mode, a rising edge on a source's active bit captures that source's colour. The cell keeps showing that colour after the source drops, so a one-cycle pulse is enough. In additive mode, the cell shows the channel-by-channel sum of every active, non-legacy source, clamped at 255. That colour lasts only while those sources stay high.

A change gate can limit how often the visible colour changes. When fast changes are not allowed, a change is applied only after a set number of cycles has passed since the previous change. A change that is held back waits and is applied the moment the interval ends. The outputs are registered.

Top module: `pixel_latch`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `pix_rgb` to 0 and `pix_lit` to 0 after that edge.
- R2: In latch mode (`add_mode`=0, `fast_ok`=1), a 0-to-1 transition of `src_act[i]` makes `pix_rgb` equal source i's colour (`src_rgb[i*24 +: 24]`) and `pix_lit` 1, one clock edge after the cycle in which the transition is presented.
- R3: In latch mode, the captured colour and `pix_lit`=1 remain after all active bits return to 0.
- R4: In latch mode, when several sources rise in the same cycle, the lowest-indexed one is captured.
- R5: In additive mode (`add_mode`=1), `pix_rgb` equals the sum of the colours of the active sources, computed separately for the red (bits 23:16), green (15:8) and blue (7:0) channels, and `pix_lit` is 1.
- R6: In additive mode, a channel whose sum exceeds 255 shows 255, without affecting the other channels.
- R7: In additive mode, a source with `src_leg[i]`=1 contributes nothing, even while active.
- R8: In additive mode with no active non-legacy source, `pix_rgb` is 0 and `pix_lit` is 0.
- R9: With `fast_ok`=0, the pair (`pix_rgb`, `pix_lit`) does not change within `GAP` clock edges of its previous change; a change made with `fast_ok`=1 also starts that interval.
- R10: A change blocked by R9 is kept pending, and the most recent wanted value is applied at exactly the `GAP`-th edge after the previous change.
- R11: With `fast_ok`=1, the output follows each new wanted value after one edge, on consecutive changes.
- R12: In latch mode, a source that stays high does not capture again. Only a new rising edge captures, so a source rising later overrides a source that was already held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| add_mode | input | 1 | 1 = additive sum, 0 = latch last rising source |
| fast_ok | input | 1 | 1 = no minimum interval between colour changes |
| src_act | input | K | Active bit per source |
| src_leg | input | K | Legacy flag per source (excluded from the sum) |
| src_rgb | input | 24*K | Colour per source, source i at bits [i*24 +: 24] |
| pix_rgb | output | 24 | Current pixel colour |
| pix_lit | output | 1 | Pixel shows a colour |

## Verification
Two events can fall in the same cycle: a source rising while the change gate is still closed, and the gate's interval expiring. Both can also meet a second rising source that replaces the pending colour. The bench makes one change with the gate active. It then raises one source during the closed window and later raises a different source. It checks that the output holds the old colour for every closed cycle. It then checks that the later colour appears on exactly the edge where the interval ends.

// File: rtl/pixel_latch.sv
module pixel_latch #(
  parameter int K   = 4,
  parameter int CH  = 8,
  parameter int GAP = 25_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              add_mode,
  input  logic              fast_ok,
  input  logic [K-1:0]      src_act,
  input  logic [K-1:0]      src_leg,
  input  logic [3*CH*K-1:0] src_rgb,
  output logic [3*CH-1:0]   pix_rgb,
  output logic              pix_lit
);
  localparam int PW = 3 * CH;
  localparam int SW = CH + $clog2(K + 1);
  localparam int CW = $clog2(GAP + 1);

  logic [K-1:0]    prev_act;
  logic [K-1:0]    rise;
  logic [PW-1:0]   lat_rgb, pick_rgb, sum_rgb, want_rgb;
  logic            lat_lit, want_lit, go;
  logic [CW-1:0]   gap_cnt;

  assign rise = src_act & ~prev_act;

  always_comb begin
    pick_rgb = '0;
    for (int i = K - 1; i >= 0; i--)
      if (rise[i]) pick_rgb = src_rgb[i*PW +: PW];
  end

  for (genvar c = 0; c < 3; c++) begin : g_chan
    logic [SW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int i = 0; i < K; i++)
        if (src_act[i] && !src_leg[i])
          acc = acc + SW'(src_rgb[i*PW + c*CH +: CH]);
    end
    assign sum_rgb[c*CH +: CH] = ((acc >> CH) != '0) ? {CH{1'b1}} : acc[CH-1:0];
  end

  assign want_rgb = add_mode ? sum_rgb : ((|rise) ? pick_rgb : lat_rgb);
  assign want_lit = add_mode ? |(src_act & ~src_leg) : ((|rise) | lat_lit);
  assign go = ((want_rgb != pix_rgb) || (want_lit != pix_lit)) &&
              (fast_ok || gap_cnt == '0);

  always_ff @(posedge clk) begin
    prev_act <= src_act;
    if (rst) begin
      lat_rgb <= '0;
      lat_lit <= 1'b0;
      pix_rgb <= '0;
      pix_lit <= 1'b0;
      gap_cnt <= '0;
    end else begin
      if (!add_mode && (|rise)) begin
        lat_rgb <= pick_rgb;
        lat_lit <= 1'b1;
      end
      if (go) begin
        pix_rgb <= want_rgb;
        pix_lit <= want_lit;
        gap_cnt <= CW'(GAP - 1);
      end else if (gap_cnt != '0) begin
        gap_cnt <= gap_cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/pixel_latch_chk.sv
module pixel_latch_chk #(
  parameter int K   = 4,
  parameter int CH  = 8,
  parameter int GAP = 25_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic              add_mode,
  input logic              fast_ok,
  input logic [K-1:0]      src_act,
  input logic [K-1:0]      src_leg,
  input logic [3*CH*K-1:0] src_rgb,
  input logic [3*CH-1:0]   pix_rgb,
  input logic              pix_lit
);
  localparam int CW = $clog2(GAP + 2);

  logic [3*CH-1:0] prev_rgb;
  logic            prev_lit;
  logic [CW-1:0]   since;
  logic            chg;

  assign chg = (pix_rgb != prev_rgb) || (pix_lit != prev_lit);

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rgb <= '0;
      prev_lit <= 1'b0;
      since    <= CW'(GAP);
    end else begin
      prev_rgb <= pix_rgb;
      prev_lit <= pix_lit;
      if (chg) since <= CW'(1);
      else if (since < CW'(GAP)) since <= since + 1'b1;
    end
  end

  AST_RATE_GAP: assert property (@(posedge clk) disable iff (rst)
    (chg && !$past(fast_ok)) |-> (since >= CW'(GAP))); // R9

  AST_LATCH_LIT: assert property (@(posedge clk) disable iff (rst)
    (!add_mode && fast_ok && (|(src_act & ~$past(src_act)))) |=> pix_lit); // R2

  AST_LOW_INDEX_WINS: assert property (@(posedge clk) disable iff (rst)
    (!add_mode && fast_ok && src_act[0] && !$past(src_act[0]))
    |=> (pix_rgb == $past(src_rgb[3*CH-1:0]))); // R4

  AST_ADD_IDLE_DARK: assert property (@(posedge clk) disable iff (rst)
    (add_mode && fast_ok && src_act == '0) |=> (pix_rgb == '0 && !pix_lit)); // R8

  AST_LEGACY_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (add_mode && fast_ok && src_act != '0 && (src_act & ~src_leg) == '0)
    |=> (pix_rgb == '0 && !pix_lit)); // R7
endmodule

bind pixel_latch pixel_latch_chk #(.K(K), .CH(CH), .GAP(GAP)) chk_i (
  .clk(clk), .rst(rst), .add_mode(add_mode), .fast_ok(fast_ok),
  .src_act(src_act), .src_leg(src_leg), .src_rgb(src_rgb),
  .pix_rgb(pix_rgb), .pix_lit(pix_lit));

// File: tb/pixel_latch_tb_top.sv
module pixel_latch_tb_top;
  localparam int K = 3;
  localparam int GAP = 6;
  localparam int PERIOD = 10;
  localparam logic [23:0] C0 = 24'h102030;
  localparam logic [23:0] C1 = 24'h405060;
  localparam logic [23:0] C2 = 24'hF00810;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic add_mode = 1'b0, fast_ok = 1'b1;
  logic [K-1:0] src_act = '0, src_leg = '0;
  logic [24*K-1:0] src_rgb = {C2, C1, C0};
  logic [23:0] pix_rgb;
  logic pix_lit;
  int cyc = 0, checks = 0, fails = 0;

  typedef struct { int due; logic [23:0] rgb; logic lit; string tag; } exp_t;
  exp_t q[$];

  pixel_latch #(.K(K), .CH(8), .GAP(GAP)) dut_i (
    .clk(clk), .rst(rst), .add_mode(add_mode), .fast_ok(fast_ok),
    .src_act(src_act), .src_leg(src_leg), .src_rgb(src_rgb),
    .pix_rgb(pix_rgb), .pix_lit(pix_lit));

  always #(PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic step(input logic r, input logic a, input logic f,
                      input logic [K-1:0] act, input logic [K-1:0] leg,
                      input bit chk, input logic [23:0] er, input logic el,
                      input string tag);
    exp_t e;
    @(posedge clk); #2;
    rst = r; add_mode = a; fast_ok = f; src_act = act; src_leg = leg;
    if (chk) begin
      e.due = cyc + 1; e.rgb = er; e.lit = el; e.tag = tag;
      q.push_back(e);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due == cyc) begin
        e = q.pop_front();
        checks++;
        if (pix_rgb !== e.rgb || pix_lit !== e.lit) begin
          fails++;
          $display("FAIL %s: rgb=%h lit=%b expected rgb=%h lit=%b",
                   e.tag, pix_rgb, pix_lit, e.rgb, e.lit);
        end
      end
    end
  end

  initial begin : watchdog
    #(PERIOD * 20000);
    fails++; checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    step(1, 0, 1, 3'b000, 3'b000, 1, 24'h0, 0, "R1 reset");
    step(1, 0, 1, 3'b000, 3'b000, 0, 24'h0, 0, "");
    step(0, 0, 1, 3'b000, 3'b000, 1, 24'h0, 0, "R1 after reset");
    // latch mode
    step(0, 0, 1, 3'b001, 3'b000, 1, C0, 1, "R2 capture src0");
    step(0, 0, 1, 3'b000, 3'b000, 1, C0, 1, "R3 hold after drop");
    step(0, 0, 1, 3'b000, 3'b000, 1, C0, 1, "R3 hold");
    step(0, 0, 1, 3'b110, 3'b000, 1, C1, 1, "R4 lowest index of two");
    step(0, 0, 1, 3'b111, 3'b000, 1, C0, 1, "R12 new rise overrides");
    step(0, 0, 1, 3'b111, 3'b000, 1, C0, 1, "R12 held high no recapture");
    step(0, 0, 1, 3'b011, 3'b000, 1, C0, 1, "R12 fall no capture");
    // additive mode
    step(0, 1, 1, 3'b011, 3'b000, 1, 24'h507090, 1, "R5 sum src0+src1");
    step(0, 1, 1, 3'b110, 3'b000, 1, 24'hFF5870, 1, "R6 red clamps");
    step(0, 1, 1, 3'b001, 3'b000, 1, C0, 1, "R5 single source");
    step(0, 1, 1, 3'b000, 3'b000, 1, 24'h0, 0, "R8 none active");
    step(0, 1, 1, 3'b011, 3'b010, 1, C0, 1, "R7 legacy src1 skipped");
    step(0, 1, 1, 3'b010, 3'b010, 1, 24'h0, 0, "R7 only legacy active");
    for (int i = 0; i < GAP; i++)
      step(0, 1, 1, 3'b000, 3'b000, 1, 24'h0, 0, "R8 idle");
    // change gate: latched colour is C0 from the R12 steps
    step(0, 0, 0, 3'b000, 3'b000, 1, C0, 1, "R9 open gate applies");
    step(0, 0, 0, 3'b100, 3'b000, 1, C0, 1, "R9 blocked 1");
    step(0, 0, 0, 3'b000, 3'b000, 1, C0, 1, "R9 blocked 2");
    step(0, 0, 0, 3'b010, 3'b000, 1, C0, 1, "R9 blocked 3");
    step(0, 0, 0, 3'b010, 3'b000, 1, C0, 1, "R9 blocked 4");
    step(0, 0, 0, 3'b010, 3'b000, 1, C0, 1, "R9 blocked 5");
    step(0, 0, 0, 3'b010, 3'b000, 1, C1, 1, "R10 pending latest applied");
    // fast changes
    step(0, 0, 1, 3'b001, 3'b000, 1, C0, 1, "R11 fast change 1");
    step(0, 0, 1, 3'b100, 3'b000, 1, C2, 1, "R11 fast change 2");
    step(0, 0, 1, 3'b010, 3'b000, 1, C1, 1, "R11 fast change 3");
    step(0, 0, 1, 3'b000, 3'b000, 1, C1, 1, "R3 hold after fast");
    step(1, 0, 1, 3'b000, 3'b000, 1, 24'h0, 0, "R1 mid-run reset");
    step(0, 0, 1, 3'b000, 3'b000, 1, 24'h0, 0, "R1 cleared latch");
    repeat (3) @(posedge clk);
    #3;
    if (q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d items left, expected 0", q.size());
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule